// File: doc/BRIEF.md
# Half-Duplex Byte Link Endpoint

This block is one end of a symmetric, byte-wide parallel link between two processors. The two ends share one set of data wires. Each end also has an outgoing strobe, acknowledge and attention line, and the matching incoming lines come from the other end. A direction output controls an external bus transceiver. Either end may claim the link while it is idle. The end that wins sends one whole packet. While it does, the other end can only receive.

On the local side, bytes to send enter on a valid/ready stream. The first beat of every packet is its length: a value of 0 means 256 data bytes, and any other value means that many. Received data bytes leave on a second valid/ready stream, with start and end marks. The length byte is used inside the block and never appears on that stream. When a length byte arrives, the block raises a single-cycle interrupt, so the local processor is interrupted once per packet rather than once per byte.

Each byte crosses with a four-phase handshake. The incoming strobe, acknowledge and attention lines pass through a synchronizer. The receiver does not raise its acknowledge until its local consumer has taken the byte, so it may take as long as it needs.

Top module: `hslink_endpoint`

## Requirements
- R1: After a synchronous active-low reset, every link output (strobe, acknowledge, attention, direction) is low, and `tx_ready`, `rx_valid`, `irq` and `rx_pkt_active` are low.
- R2: The data bytes of a packet appear on the receiving end's stream in the order they were sent, without the leading length byte. `rx_sop` is high on the first data byte and `rx_eop` is high on the last.
- R3: A length byte of 0 carries 256 data bytes; any other value N carries N data bytes.
- R4: For each packet, the receiving end raises `irq` for exactly one cycle. It does this when the length byte arrives and never for a data byte.
- R5: An end drives the shared data wires (`ln_dir_o` high) only while it owns the link and holds its attention line high. The two ends never drive at the same time.
- R6: Strobe rises only while the synchronized acknowledge is low, and falls only after the synchronized acknowledge has been seen high. Acknowledge rises only while the synchronized strobe is high, and falls only after the synchronized strobe has been seen low.
- R7: While a received byte is held on `rx_valid` with `rx_ready` low, the byte and `rx_valid` stay unchanged and acknowledge stays low. The sender then keeps its strobe high and does not accept another local byte.
- R8: If both ends start requesting in the same cycle, the end built with `PRIMARY=1` sends its whole packet first. The other end withdraws and sends its packet after the link has gone idle.
- R9: While an end owns the link, it presents no received byte. The peer's `tx_ready` stays low for the whole packet.
- R10: `rx_pkt_active` rises when a length byte is received. It falls when the last data byte of that packet is accepted locally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_valid | input | 1 | Local byte to send is valid |
| tx_ready | output | 1 | Byte accepted this cycle when high with `tx_valid` |
| tx_data | input | DATA_W | Byte to send; the first beat of a packet is the length |
| rx_valid | output | 1 | Received data byte is present |
| rx_ready | input | 1 | Local consumer takes the byte |
| rx_data | output | DATA_W | Received data byte |
| rx_sop | output | 1 | First data byte of a packet |
| rx_eop | output | 1 | Last data byte of a packet |
| rx_pkt_active | output | 1 | A received packet is in progress |
| irq | output | 1 | One-cycle pulse on each received packet start |
| ln_data_i | input | DATA_W | Shared data wires as seen from this end |
| ln_data_o | output | DATA_W | Value this end places on the shared data wires |
| ln_dir_o | output | 1 | Transceiver direction: high drives the wires outward |
| ln_stb_o | output | 1 | Outgoing strobe |
| ln_stb_i | input | 1 | Peer's strobe |
| ln_ack_o | output | 1 | Outgoing acknowledge |
| ln_ack_i | input | 1 | Peer's acknowledge |
| ln_att_o | output | 1 | Attention: this end requests or holds the link |
| ln_att_i | input | 1 | Peer's attention |

## Verification
A wrong ownership state shows up as both direction outputs high, or as a byte presented to the owner's local stream. Either appears within a handful of cycles of the request and is caught on the next clock. A wrong packet counter shows up as a misplaced `rx_eop` or as a packet that never ends. The first case is visible on the byte itself; the second leaves the receiver stuck with `rx_pkt_active` high and the link never going idle. A broken handshake shows up as a stalled or duplicated byte, which the per-clock comparison with the expected byte queue exposes at the very next beat.

// File: rtl/hslink_pkg.sv
// Shared state encodings for the half-duplex link endpoint.
// Assumes nothing beyond the importing modules using these names.
package hslink_pkg;

    // Ownership role of one endpoint on the shared link
    typedef enum logic [1:0] {
        ROLE_IDLE,
        ROLE_REQ,
        ROLE_OWN,
        ROLE_RECV
    } role_e;

    // Sending handshake phase
    typedef enum logic [1:0] {
        TX_IDLE,
        TX_SETUP,
        TX_STB,
        TX_REL
    } tx_st_e;

    // Receiving handshake phase
    typedef enum logic [1:0] {
        RX_WAIT,
        RX_HOLD,
        RX_ACK
    } rx_st_e;

endpackage

// File: rtl/hslink_sync.sv
// Multi-flop synchronizer for the incoming control lines.
// Assumes every bit is an independent level signal; no bus coherence is given.
module hslink_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] pipe [STAGES];

    // Shift the raw inputs through STAGES flops
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) pipe[i] <= '0;
        end else begin
            pipe[0] <= d;
            for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
        end
    end

    assign q = pipe[STAGES-1];

endmodule

// File: rtl/hslink_arb.sv
// Link ownership arbiter. A request raises attention and waits GRANT_WAIT
// cycles. If the peer's attention is seen during that wait, a secondary end
// withdraws and becomes receiver; a primary end ignores it and takes the link.
// Assumes GRANT_WAIT covers the round trip through both synchronizers.
module hslink_arb
    import hslink_pkg::*;
#(
    parameter bit PRIMARY    = 1'b1,
    parameter int GRANT_WAIT = 8
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  tx_want,
    input  logic  att_s,
    input  logic  tx_done,
    input  logic  rx_idle,
    output role_e role,
    output logic  att_o
);

    localparam int CW = $clog2(GRANT_WAIT + 1);

    logic [CW-1:0] wait_cnt;

    // Role transitions and the attention line
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            role     <= ROLE_IDLE;
            att_o    <= 1'b0;
            wait_cnt <= '0;
        end else begin
            case (role)
                ROLE_IDLE: begin
                    if (att_s) begin
                        role <= ROLE_RECV;
                    end else if (tx_want) begin
                        role     <= ROLE_REQ;
                        att_o    <= 1'b1;
                        wait_cnt <= '0;
                    end
                end
                ROLE_REQ: begin
                    if (att_s && !PRIMARY) begin
                        role  <= ROLE_RECV;
                        att_o <= 1'b0;
                    end else if (wait_cnt == CW'(GRANT_WAIT - 1)) begin
                        role <= ROLE_OWN;
                    end else begin
                        wait_cnt <= wait_cnt + CW'(1);
                    end
                end
                ROLE_OWN: begin
                    if (tx_done) begin
                        role  <= ROLE_IDLE;
                        att_o <= 1'b0;
                    end
                end
                ROLE_RECV: begin
                    if (!att_s && rx_idle) role <= ROLE_IDLE;
                end
                default: role <= ROLE_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/hslink_tx.sv
// Sending handshake engine. Takes local bytes only while enabled (link owned).
// The first byte of a packet is the length; the engine reports done once the
// peer has released its acknowledge for the last data byte.
// Assumes ack_s is already synchronized.
module hslink_tx
    import hslink_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          tx_valid,
    output logic          tx_ready,
    input  logic [DW-1:0] tx_data,
    input  logic          ack_s,
    output logic          stb_o,
    output logic [DW-1:0] bus_o,
    output logic          done
);

    localparam int CW = DW + 1;

    tx_st_e        st;
    logic [CW-1:0] rem;
    logic          in_pkt;
    logic          last;

    assign tx_ready = en && (st == TX_IDLE);
    assign done     = (st == TX_REL) && !ack_s && last;

    // Byte loading, strobe sequencing and packet length counting
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= TX_IDLE;
            stb_o  <= 1'b0;
            bus_o  <= '0;
            rem    <= '0;
            in_pkt <= 1'b0;
            last   <= 1'b0;
        end else begin
            case (st)
                TX_IDLE: begin
                    if (tx_ready && tx_valid) begin
                        bus_o <= tx_data;
                        st    <= TX_SETUP;
                        if (!in_pkt) begin
                            in_pkt <= 1'b1;
                            last   <= 1'b0;
                            rem    <= (tx_data == '0) ? {1'b1, {DW{1'b0}}}
                                                      : {1'b0, tx_data};
                        end else begin
                            rem  <= rem - CW'(1);
                            last <= (rem == CW'(1));
                        end
                    end
                end
                TX_SETUP: begin
                    stb_o <= 1'b1;
                    st    <= TX_STB;
                end
                TX_STB: begin
                    if (ack_s) begin
                        stb_o <= 1'b0;
                        st    <= TX_REL;
                    end
                end
                TX_REL: begin
                    if (!ack_s) begin
                        st <= TX_IDLE;
                        if (last) begin
                            in_pkt <= 1'b0;
                            last   <= 1'b0;
                        end
                    end
                end
                default: st <= TX_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/hslink_rx.sv
// Receiving handshake engine. Latches the bus once the synchronized strobe is
// high. A length byte is used internally and acknowledged at once; a data byte
// is held on the local stream and acknowledged only after it is accepted.
// Assumes the sender keeps the data stable from before its strobe until the
// acknowledge is seen.
module hslink_rx
    import hslink_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          stb_s,
    input  logic [DW-1:0] bus_i,
    input  logic          rx_ready,
    output logic          ack_o,
    output logic          rx_valid,
    output logic [DW-1:0] rx_data,
    output logic          rx_sop,
    output logic          rx_eop,
    output logic          pkt_active,
    output logic          pkt_start,
    output logic          idle
);

    localparam int CW = DW + 1;

    rx_st_e        st;
    logic [CW-1:0] rem;
    logic          first;

    assign idle = (st == RX_WAIT) && !pkt_active;

    // Byte capture, local hand-off and acknowledge sequencing
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st         <= RX_WAIT;
            ack_o      <= 1'b0;
            rx_valid   <= 1'b0;
            rx_data    <= '0;
            rx_sop     <= 1'b0;
            rx_eop     <= 1'b0;
            pkt_active <= 1'b0;
            pkt_start  <= 1'b0;
            rem        <= '0;
            first      <= 1'b0;
        end else begin
            pkt_start <= 1'b0;
            case (st)
                RX_WAIT: begin
                    if (en && stb_s) begin
                        if (!pkt_active) begin
                            pkt_active <= 1'b1;
                            pkt_start  <= 1'b1;
                            first      <= 1'b1;
                            rem        <= (bus_i == '0) ? {1'b1, {DW{1'b0}}}
                                                        : {1'b0, bus_i};
                            ack_o      <= 1'b1;
                            st         <= RX_ACK;
                        end else begin
                            rx_data  <= bus_i;
                            rx_valid <= 1'b1;
                            rx_sop   <= first;
                            rx_eop   <= (rem == CW'(1));
                            st       <= RX_HOLD;
                        end
                    end
                end
                RX_HOLD: begin
                    if (rx_ready) begin
                        rx_valid <= 1'b0;
                        ack_o    <= 1'b1;
                        first    <= 1'b0;
                        rem      <= rem - CW'(1);
                        if (rx_eop) pkt_active <= 1'b0;
                        st       <= RX_ACK;
                    end
                end
                RX_ACK: begin
                    if (!stb_s) begin
                        ack_o <= 1'b0;
                        st    <= RX_WAIT;
                    end
                end
                default: st <= RX_WAIT;
            endcase
        end
    end

endmodule

// File: rtl/hslink_endpoint.sv
// One end of a symmetric half-duplex byte link. Joins the synchronizer, the
// ownership arbiter and the two handshake engines. Its data wires reach the
// peer through an external transceiver controlled by ln_dir_o.
// Assumes the peer is another instance with the opposite PRIMARY setting and
// the same SYNC_STAGES.
module hslink_endpoint
    import hslink_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter bit PRIMARY     = 1'b1,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_valid,
    output logic              tx_ready,
    input  logic [DATA_W-1:0] tx_data,
    output logic              rx_valid,
    input  logic              rx_ready,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_sop,
    output logic              rx_eop,
    output logic              rx_pkt_active,
    output logic              irq,
    input  logic [DATA_W-1:0] ln_data_i,
    output logic [DATA_W-1:0] ln_data_o,
    output logic              ln_dir_o,
    output logic              ln_stb_o,
    input  logic              ln_stb_i,
    output logic              ln_ack_o,
    input  logic              ln_ack_i,
    output logic              ln_att_o,
    input  logic              ln_att_i
);

    localparam int GRANT_WAIT = 2 * SYNC_STAGES + 4;

    logic [2:0] sync_q;
    logic       att_s;
    logic       stb_s;
    logic       ack_s;
    role_e      role;
    logic       own;
    logic       recv;
    logic       tx_done;
    logic       rx_idle;
    logic       pkt_start;

    hslink_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({ln_att_i, ln_stb_i, ln_ack_i}),
        .q     (sync_q)
    );

    assign {att_s, stb_s, ack_s} = sync_q;
    assign own  = (role == ROLE_OWN);
    assign recv = (role == ROLE_RECV);

    hslink_arb #(.PRIMARY(PRIMARY), .GRANT_WAIT(GRANT_WAIT)) u_arb (
        .clk     (clk),
        .rst_n   (rst_n),
        .tx_want (tx_valid),
        .att_s   (att_s),
        .tx_done (tx_done),
        .rx_idle (rx_idle),
        .role    (role),
        .att_o   (ln_att_o)
    );

    hslink_tx #(.DW(DATA_W)) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (own),
        .tx_valid (tx_valid),
        .tx_ready (tx_ready),
        .tx_data  (tx_data),
        .ack_s    (ack_s),
        .stb_o    (ln_stb_o),
        .bus_o    (ln_data_o),
        .done     (tx_done)
    );

    hslink_rx #(.DW(DATA_W)) u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (recv),
        .stb_s      (stb_s),
        .bus_i      (ln_data_i),
        .rx_ready   (rx_ready),
        .ack_o      (ln_ack_o),
        .rx_valid   (rx_valid),
        .rx_data    (rx_data),
        .rx_sop     (rx_sop),
        .rx_eop     (rx_eop),
        .pkt_active (rx_pkt_active),
        .pkt_start  (pkt_start),
        .idle       (rx_idle)
    );

    assign irq      = pkt_start;
    assign ln_dir_o = own;

endmodule

// File: rtl/hslink_endpoint_chk.sv
// Protocol checker for one link endpoint, bound to every instance.
// Assumes the synchronized strobe and acknowledge are reachable by name.
module hslink_endpoint_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ln_stb_o,
    input logic              ln_ack_o,
    input logic              ln_dir_o,
    input logic              ln_att_o,
    input logic              rx_valid,
    input logic              rx_ready,
    input logic [DATA_W-1:0] rx_data,
    input logic              irq,
    input logic              stb_s,
    input logic              ack_s
);

    AST_STB_RISE_ACK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ln_stb_o) |-> !$past(ack_s)); // R6
    AST_STB_FALL_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ln_stb_o) |-> $past(ack_s)); // R6
    AST_ACK_RISE_ON_STB: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ln_ack_o) |-> $past(stb_s)); // R6
    AST_ACK_FALL_AFTER_STB: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ln_ack_o) |-> !$past(stb_s)); // R6
    AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq); // R4
    AST_HOLD_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data))); // R7
    AST_NO_ACK_WHILE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> !ln_ack_o); // R7
    AST_DRIVE_NEEDS_ATT: assert property (@(posedge clk) disable iff (!rst_n)
        ln_dir_o |-> ln_att_o); // R5
    AST_OWNER_NO_RX: assert property (@(posedge clk) disable iff (!rst_n)
        ln_dir_o |-> !rx_valid); // R9

endmodule

bind hslink_endpoint hslink_endpoint_chk #(.DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ln_stb_o (ln_stb_o),
    .ln_ack_o (ln_ack_o),
    .ln_dir_o (ln_dir_o),
    .ln_att_o (ln_att_o),
    .rx_valid (rx_valid),
    .rx_ready (rx_ready),
    .rx_data  (rx_data),
    .irq      (irq),
    .stb_s    (stb_s),
    .ack_s    (ack_s)
);

// File: tb/tb_hslink_endpoint.sv
`timescale 1ns/1ps
// Two endpoints wired back to back. A behavioural model of expected bytes per
// direction is compared on every clock.
module tb_hslink_endpoint;

    localparam int DW = 8;

    logic clk = 1'b0;
    always #2 clk = ~clk;
    logic rst_n;

    logic          a_tx_valid, a_tx_ready, a_rx_valid, a_rx_ready, a_rx_sop, a_rx_eop;
    logic          a_act, a_irq, a_dir, a_stb, a_ack, a_att;
    logic [DW-1:0] a_tx_data, a_rx_data, a_do;
    logic          b_tx_valid, b_tx_ready, b_rx_valid, b_rx_ready, b_rx_sop, b_rx_eop;
    logic          b_act, b_irq, b_dir, b_stb, b_ack, b_att;
    logic [DW-1:0] b_tx_data, b_rx_data, b_do;
    logic [DW-1:0] bus;

    assign bus = a_dir ? a_do : (b_dir ? b_do : '0);

    hslink_endpoint #(.DATA_W(DW), .PRIMARY(1'b1)) dut (
        .clk(clk), .rst_n(rst_n),
        .tx_valid(a_tx_valid), .tx_ready(a_tx_ready), .tx_data(a_tx_data),
        .rx_valid(a_rx_valid), .rx_ready(a_rx_ready), .rx_data(a_rx_data),
        .rx_sop(a_rx_sop), .rx_eop(a_rx_eop), .rx_pkt_active(a_act), .irq(a_irq),
        .ln_data_i(bus), .ln_data_o(a_do), .ln_dir_o(a_dir),
        .ln_stb_o(a_stb), .ln_stb_i(b_stb), .ln_ack_o(a_ack), .ln_ack_i(b_ack),
        .ln_att_o(a_att), .ln_att_i(b_att)
    );

    hslink_endpoint #(.DATA_W(DW), .PRIMARY(1'b0)) dut_peer (
        .clk(clk), .rst_n(rst_n),
        .tx_valid(b_tx_valid), .tx_ready(b_tx_ready), .tx_data(b_tx_data),
        .rx_valid(b_rx_valid), .rx_ready(b_rx_ready), .rx_data(b_rx_data),
        .rx_sop(b_rx_sop), .rx_eop(b_rx_eop), .rx_pkt_active(b_act), .irq(b_irq),
        .ln_data_i(bus), .ln_data_o(b_do), .ln_dir_o(b_dir),
        .ln_stb_o(b_stb), .ln_stb_i(a_stb), .ln_ack_o(b_ack), .ln_ack_i(a_ack),
        .ln_att_o(b_att), .ln_att_i(a_att)
    );

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    int irq_a = 0, irq_b = 0;
    int rcv_ab = 0, rcv_ba = 0;
    int ab_last_cyc = 0, ba_first_cyc = -1;
    bit a_stall = 0, b_stall = 0;
    bit done_flag = 0;
    logic [DW+1:0] exp_ab[$];
    logic [DW+1:0] exp_ba[$];

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    function automatic logic [DW-1:0] pat(input int seed, input int i);
        return DW'((seed + i * 7) & 255);
    endfunction

    // Model: the expected {sop, eop, byte} sequence, then drive the A stream
    task automatic send_a(input int len, input int seed);
        int n = (len == 0) ? 256 : len;
        for (int i = 0; i < n; i++) exp_ab.push_back({i == 0, i == n - 1, pat(seed, i)});
        @(negedge clk); a_tx_valid = 1'b1; a_tx_data = DW'(len);
        while (!a_tx_ready) @(negedge clk);
        @(posedge clk);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); a_tx_data = pat(seed, i);
            while (!a_tx_ready) @(negedge clk);
            @(posedge clk);
        end
        @(negedge clk); a_tx_valid = 1'b0;
    endtask

    task automatic send_b(input int len, input int seed);
        int n = (len == 0) ? 256 : len;
        for (int i = 0; i < n; i++) exp_ba.push_back({i == 0, i == n - 1, pat(seed, i)});
        @(negedge clk); b_tx_valid = 1'b1; b_tx_data = DW'(len);
        while (!b_tx_ready) @(negedge clk);
        @(posedge clk);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); b_tx_data = pat(seed, i);
            while (!b_tx_ready) @(negedge clk);
            @(posedge clk);
        end
        @(negedge clk); b_tx_valid = 1'b0;
    endtask

    task automatic wait_quiet();
        int quiet = 0;
        while (quiet < 30) begin
            @(negedge clk);
            if (exp_ab.size() == 0 && exp_ba.size() == 0 && !a_att && !b_att
                && !a_act && !b_act) quiet++;
            else quiet = 0;
        end
    endtask

    // Per-clock monitor: drive exclusion, peer lockout and interrupt counts
    initial begin
        forever begin
            @(negedge clk);
            cyc++;
            if (rst_n) begin
                check(!(a_dir && b_dir), "R5", "both ends drive", int'(b_dir), 0);
                check(!(a_dir && b_tx_ready), "R9", "peer tx_ready while A owns", int'(b_tx_ready), 0);
                check(!(b_dir && a_tx_ready), "R9", "peer tx_ready while B owns", int'(a_tx_ready), 0);
                if (a_irq) irq_a++;
                if (b_irq) irq_b++;
            end
        end
    end

    // Consumer at B: compare every clock with the A-to-B model
    initial begin
        b_rx_ready = 1'b0;
        forever begin
            @(negedge clk);
            b_rx_ready = !b_stall;
            if (rst_n && b_rx_valid) begin
                if (exp_ab.size() == 0) begin
                    check(1'b0, "R2", "unexpected byte at B", int'(b_rx_data), -1);
                end else begin
                    check({b_rx_sop, b_rx_eop, b_rx_data} == exp_ab[0], "R2",
                          "B byte/sop/eop", int'({b_rx_sop, b_rx_eop, b_rx_data}), int'(exp_ab[0]));
                    if (b_rx_ready) begin
                        void'(exp_ab.pop_front());
                        rcv_ab++;
                        ab_last_cyc = cyc;
                    end
                end
            end
        end
    end

    // Consumer at A: compare every clock with the B-to-A model
    initial begin
        a_rx_ready = 1'b0;
        forever begin
            @(negedge clk);
            a_rx_ready = !a_stall;
            if (rst_n && a_rx_valid) begin
                if (exp_ba.size() == 0) begin
                    check(1'b0, "R2", "unexpected byte at A", int'(a_rx_data), -1);
                end else begin
                    check({a_rx_sop, a_rx_eop, a_rx_data} == exp_ba[0], "R2",
                          "A byte/sop/eop", int'({a_rx_sop, a_rx_eop, a_rx_data}), int'(exp_ba[0]));
                    if (a_rx_ready) begin
                        void'(exp_ba.pop_front());
                        rcv_ba++;
                        if (ba_first_cyc < 0) ba_first_cyc = cyc;
                    end
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done_flag) begin
            n_chk++; n_fail++;
            $display("FAIL R2 watchdog: actual %0d expected %0d", cyc, 0);
            summary();
            $finish;
        end
    end

    initial begin
        int base;
        rst_n = 1'b0;
        a_tx_valid = 1'b0; a_tx_data = '0;
        b_tx_valid = 1'b0; b_tx_data = '0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        check(!a_stb && !a_ack && !a_att && !a_dir, "R1", "A link outputs", int'({a_stb, a_ack, a_att, a_dir}), 0);
        check(!b_stb && !b_ack && !b_att && !b_dir, "R1", "B link outputs", int'({b_stb, b_ack, b_att, b_dir}), 0);
        check(!a_tx_ready && !a_rx_valid && !a_irq && !a_act, "R1", "A stream outputs",
              int'({a_tx_ready, a_rx_valid, a_irq, a_act}), 0);
        check(!b_tx_ready && !b_rx_valid && !b_irq && !b_act, "R1", "B stream outputs",
              int'({b_tx_ready, b_rx_valid, b_irq, b_act}), 0);
        rst_n = 1'b1;
        repeat (10) @(negedge clk);
        check(!a_att && !b_att, "R1", "no request when idle", int'({a_att, b_att}), 0);

        // R2/R4: short packets in each direction
        send_a(3, 10); wait_quiet();
        check(irq_b == 1, "R4", "B interrupts after one packet", irq_b, 1);
        check(rcv_ab == 3, "R2", "bytes at B", rcv_ab, 3);
        check(!b_act, "R10", "B packet flag cleared", int'(b_act), 0);
        send_b(5, 40); wait_quiet();
        check(irq_a == 1, "R4", "A interrupts after one packet", irq_a, 1);
        check(rcv_ba == 5, "R2", "bytes at A", rcv_ba, 5);
        send_a(1, 99); wait_quiet();
        send_a(17, 3); wait_quiet();
        check(irq_b == 3, "R4", "B interrupts after three packets", irq_b, 3);
        check(rcv_ab == 21, "R3", "length 1 and 17 carried", rcv_ab, 21);

        // R7/R10: receiver stall holds the handshake
        b_stall = 1'b1;
        fork send_a(4, 60); join_none
        repeat (80) @(negedge clk);
        check(b_rx_valid == 1'b1, "R7", "B holds byte", int'(b_rx_valid), 1);
        check(b_rx_data == pat(60, 0), "R7", "held byte", int'(b_rx_data), int'(pat(60, 0)));
        check(!b_ack, "R7", "no ack while held", int'(b_ack), 0);
        check(a_stb, "R7", "sender strobe held", int'(a_stb), 1);
        check(!a_tx_ready, "R7", "sender takes no byte", int'(a_tx_ready), 0);
        check(b_act, "R10", "B packet flag during packet", int'(b_act), 1);
        b_stall = 1'b0;
        wait_quiet();
        check(rcv_ab == 25, "R7", "bytes after release", rcv_ab, 25);

        // R8: simultaneous requests, primary first
        ba_first_cyc = -1;
        fork
            send_a(6, 20);
            send_b(6, 80);
        join
        wait_quiet();
        check(ab_last_cyc < ba_first_cyc, "R8", "primary packet done first", ab_last_cyc, ba_first_cyc);
        check(rcv_ba == 11 && rcv_ab == 31, "R8", "both packets delivered", rcv_ab + rcv_ba, 42);

        // R3: length byte 0 means 256 bytes
        base = rcv_ab;
        send_a(0, 5); wait_quiet();
        check(rcv_ab - base == 256, "R3", "bytes for length 0", rcv_ab - base, 256);
        check(irq_b == 6, "R4", "one interrupt for 256 bytes", irq_b, 6);
        check(exp_ab.size() == 0 && exp_ba.size() == 0, "R2", "model queues drained",
              exp_ab.size() + exp_ba.size(), 0);

        done_flag = 1'b1;
        summary();
        $finish;
    end

endmodule